// File: doc/BRIEF.md
# Stereo De-emphasis Shelving Filter

This block restores the flat response of audio that was pre-emphasised before recording or transmission. It is a fixed first-order shelf with a pole from a 50 µs time constant, corner near 3.18 kHz, and a zero from a 15 µs time constant, corner near 10.6 kHz. Gain is unity at low frequency and falls to roughly -10 dB towards Nyquist. The coefficients are fixed and tuned for 44.1 kHz. At any other rate the curve moves in proportion to the sample rate and loses accuracy.

Samples are signed PCM words with a valid strobe. A strobe carries either one channel, tagged left or right, or both channels as a pair. Each channel has its own filter history. Results leave with the same framing, a fixed two cycles later. Filtering runs only when the enable input is high and the speed-mode input says single speed. In every other case the word passes through unchanged and the history is held at zero, so that turning the filter on again starts from a clean state.

Top module: `deemph_shelf`

## Requirements
- R1: A strobe on `in_valid` in clock cycle t makes `out_valid` high in cycle t+2. Without a strobe in cycle t, `out_valid` is low in cycle t+2.
- R2: With `out_valid` high, `out_pair` and `out_chan` equal the `in_pair` and `in_chan` of the matching input strobe. `in_chan` is 0 for left and 1 for right.
- R3: When filtering, each lane computes acc = 1800992·x[n] − 250418·x[n−1] + 2643730·y[n−1]. These are the Q2.22 coefficients b0, b1 and −a1 of the bilinear design. The output is y[n] = (acc + 2^21) >>> 22, saturated to the DATA_W signed range. y[n] is also the value kept as y[n−1].
- R4: A constant input held on a channel for 300 samples gives an output within 1 LSB of the input (unity gain at DC).
- R5: An alternating ±A input gives a settled output swing between 0.28·A and 0.32·A (about −10 dB near Nyquist).
- R6: With `cfg_en` low, every output word equals its input word bit for bit.
- R7: With `cfg_speed` other than 0 (0 = single, 1 = double, 2 = quad, 3 = reserved), every output word equals its input word bit for bit, even with `cfg_en` high.
- R8: On every clock edge where filtering is not selected, both channels' histories are cleared. The first filtered sample x after re-enabling therefore gives (1800992·x + 2^21) >>> 22.
- R9: Full-scale inputs never wrap: a held −2^23 or 2^23−1 input settles within 1 LSB of itself.
- R10: Left and right keep separate histories. A single-channel strobe updates only that channel's output, and the other channel's output holds its value.
- R11: During and after synchronous reset, `out_valid` is low and both output words are zero until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Filter enable (static) |
| cfg_speed | input | 2 | Speed mode, 0 = single |
| in_valid | input | 1 | Input sample strobe |
| in_pair | input | 1 | Strobe carries both channels |
| in_chan | input | 1 | Channel of a single-channel strobe (0 left, 1 right) |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_pair | output | 1 | Echo of `in_pair` |
| out_chan | output | 1 | Echo of `in_chan` |
| out_left | output | DATA_W | Left output sample, signed |
| out_right | output | DATA_W | Right output sample, signed |

## Verification
The bench builds the block with DATA_W = 24, the width for which the coefficient set is defined. This puts the exact full-scale words −2^23 and 2^23−1 within reach, so the saturation and rounding corners can be driven directly. It also lets the reference model's 64-bit integer arithmetic reproduce each output word exactly. The model is compared against both lanes on every clock, across paired and interleaved single-channel streams, enable toggling and all four speed codes.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  // coefficient format: signed Q2.22
  localparam int COEF_W = 24;
  localparam int FRAC   = 22;

  // bilinear design, T1 = 50 us, T2 = 15 us, fs = 44.1 kHz
  // b0 = 2.323/5.41, b1 = -0.323/5.41, -a1 = 3.41/5.41
  // b0 + b1 + (-a1) equals 1.0 exactly in Q2.22 (unity DC gain)
  localparam logic signed [COEF_W-1:0] C_B0  = 24'sd1800992;
  localparam logic signed [COEF_W-1:0] C_B1  = -24'sd250418;
  localparam logic signed [COEF_W-1:0] C_NA1 = 24'sd2643730;

  localparam int NLANE = 2;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;
endpackage

// File: rtl/deemph_sat.sv
module deemph_sat #(
  parameter int IN_W  = 50,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > HI)      dout = HI[OUT_W-1:0];
    else if (din < LO) dout = LO[OUT_W-1:0];
    else               dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/deemph_capture.sv
module deemph_capture
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          filt_live,
  input  logic                          in_valid,
  input  logic                          in_pair,
  input  logic                          in_chan,
  input  logic [DATA_W-1:0]             in_left,
  input  logic [DATA_W-1:0]             in_right,
  output logic                          s1_valid,
  output logic                          s1_pair,
  output logic                          s1_chan,
  output logic                          s1_filt,
  output logic [NLANE-1:0]              s1_go,
  output logic [NLANE-1:0][DATA_W-1:0]  s1_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pair  <= 1'b0;
      s1_chan  <= 1'b0;
      s1_filt  <= 1'b0;
      s1_data  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_pair    <= in_pair;
        s1_chan    <= in_chan;
        s1_filt    <= filt_live;
        s1_data[0] <= in_left;
        s1_data[1] <= in_right;
      end
    end
  end

  // lane 0 = left, lane 1 = right
  for (genvar k = 0; k < NLANE; k++) begin : g_go
    assign s1_go[k] = s1_valid && (s1_pair || (s1_chan == k[0]));
  end
endmodule

// File: rtl/deemph_lane.sv
module deemph_lane
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic                     filt,
  input  logic                     clr,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y_q
);
  localparam int ACC_W = DATA_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] HALF =
    {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [DATA_W-1:0] x1_q, y1_q;
  logic signed [ACC_W-1:0]  p0, p1, p2, acc, scaled;
  logic signed [DATA_W-1:0] y_sat;

  always_comb begin
    p0     = ACC_W'(x)    * ACC_W'(C_B0);
    p1     = ACC_W'(x1_q) * ACC_W'(C_B1);
    p2     = ACC_W'(y1_q) * ACC_W'(C_NA1);
    acc    = p0 + p1 + p2 + HALF;
    scaled = acc >>> FRAC;
  end

  deemph_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_sat (
    .din  (scaled),
    .dout (y_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x1_q <= '0;
      y1_q <= '0;
      y_q  <= '0;
    end else begin
      if (go) y_q <= filt ? y_sat : x;
      if (go && filt) begin
        x1_q <= x;
        y1_q <= y_sat;
      end
      if (clr) begin
        x1_q <= '0;
        y1_q <= '0;
      end
    end
  end

  // R6: a bypassed sample leaves the lane unchanged
  a_r6_bypass_exact: assert property (@(posedge clk) disable iff (rst)
    (go && !filt) |=> (y_q == $past(x)));

  // R8: history is empty after any edge where filtering was off
  a_r8_history_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (x1_q == '0 && y1_q == '0));

  // R10: an idle lane keeps its output word
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(y_q));
endmodule

// File: rtl/deemph_shelf.sv
module deemph_shelf
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_en,
  input  logic [1:0]               cfg_speed,
  input  logic                     in_valid,
  input  logic                     in_pair,
  input  logic                     in_chan,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic                     out_pair,
  output logic                     out_chan,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  logic                         filt_live;
  logic                         s1_valid, s1_pair, s1_chan, s1_filt;
  logic [NLANE-1:0]             s1_go;
  logic [NLANE-1:0][DATA_W-1:0] s1_data;
  logic [NLANE-1:0][DATA_W-1:0] lane_y;

  assign filt_live = cfg_en && (speed_e'(cfg_speed) == SPD_SINGLE);

  deemph_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .filt_live (filt_live),
    .in_valid  (in_valid),
    .in_pair   (in_pair),
    .in_chan   (in_chan),
    .in_left   (in_left),
    .in_right  (in_right),
    .s1_valid  (s1_valid),
    .s1_pair   (s1_pair),
    .s1_chan   (s1_chan),
    .s1_filt   (s1_filt),
    .s1_go     (s1_go),
    .s1_data   (s1_data)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic signed [DATA_W-1:0] y_k;
    deemph_lane #(.DATA_W(DATA_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .go   (s1_go[k]),
      .filt (s1_filt),
      .clr  (!filt_live),
      .x    (signed'(s1_data[k])),
      .y_q  (y_k)
    );
    assign lane_y[k] = y_k;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pair  <= 1'b0;
      out_chan  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_pair <= s1_pair;
        out_chan <= s1_chan;
      end
    end
  end

  assign out_left  = signed'(lane_y[0]);
  assign out_right = signed'(lane_y[1]);

  // R1: fixed two-cycle latency
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R2: framing follows the sample
  a_r2_framing: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pair == $past(in_pair, 2) && out_chan == $past(in_chan, 2)));

  // R7: non-single speed passes paired words through
  a_r7_speed_bypass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pair && cfg_speed != 2'd0) |->
      ##2 (out_left == $past(in_left, 2) && out_right == $past(in_right, 2)));
endmodule

// File: tb/deemph_shelf_tb.sv
module deemph_shelf_tb;
  localparam int W = 24;
  localparam longint B0 = 1800992, B1 = -250418, NA1 = 2643730;
  localparam longint MAXV = 8388607, MINV = -8388608;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b1;
  logic [1:0] cfg_speed = 2'd0;
  logic in_valid = 1'b0, in_pair = 1'b0, in_chan = 1'b0;
  logic signed [W-1:0] in_left = '0, in_right = '0;
  logic out_valid, out_pair, out_chan;
  logic signed [W-1:0] out_left, out_right;

  int total = 0;
  int bad = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  deemph_shelf #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_speed(cfg_speed),
    .in_valid(in_valid), .in_pair(in_pair), .in_chan(in_chan),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_pair(out_pair), .out_chan(out_chan),
    .out_left(out_left), .out_right(out_right)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic string tagname(input int c);
    case (c)
      3: return "R3";
      6: return "R6";
      7: return "R7";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference model
  longint mx1 [2];
  longint my1 [2];
  longint s1x [2];
  longint moy [2];
  int     mtag [2];
  bit s1v, s1pair, s1ch, s1filt;
  bit mov, mopair, moch;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        mx1[k] = 0; my1[k] = 0; s1x[k] = 0; moy[k] = 0; mtag[k] = 11;
      end
      s1v = 0; s1pair = 0; s1ch = 0; s1filt = 0;
      mov = 0; mopair = 0; moch = 0;
    end else begin
      mov = s1v;
      if (s1v) begin
        mopair = s1pair;
        moch = s1ch;
      end
      for (int k = 0; k < 2; k++) begin
        if (s1v && (s1pair || (s1ch == k[0]))) begin
          if (s1filt) begin
            longint acc;
            acc = B0 * s1x[k] + B1 * mx1[k] + NA1 * my1[k] + 64'sd2097152;
            moy[k] = sat(acc >>> 22);
            mx1[k] = s1x[k];
            my1[k] = moy[k];
            mtag[k] = 3;
          end else begin
            moy[k] = s1x[k];
            mtag[k] = (s1filt == 0 && mtag[k] != 7 && cfgmode_en_low()) ? 6 : 7;
          end
        end else begin
          mtag[k] = 10;
        end
      end
      if (!(cfg_en && cfg_speed == 2'd0)) begin
        for (int k = 0; k < 2; k++) begin mx1[k] = 0; my1[k] = 0; end
      end
      s1v = in_valid;
      if (in_valid) begin
        s1pair = in_pair;
        s1ch = in_chan;
        s1filt = cfg_en && (cfg_speed == 2'd0);
        s1x[0] = longint'(in_left);
        s1x[1] = longint'(in_right);
      end
    end
  end

  bit cap_en_low;
  always @(posedge clk) if (in_valid) cap_en_low <= !cfg_en;
  function automatic bit cfgmode_en_low();
    return cap_en_low;
  endfunction

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == mov, "R1", longint'(out_valid), longint'(mov));
      if (mov) begin
        chk(out_pair == mopair && out_chan == moch, "R2",
            longint'({out_pair, out_chan}), longint'({mopair, moch}));
      end
      chk(longint'(out_left) == moy[0], tagname(mtag[0]), longint'(out_left), moy[0]);
      chk(longint'(out_right) == moy[1], tagname(mtag[1]), longint'(out_right), moy[1]);
    end
  end

  // stimulus helpers
  task automatic put(input bit pr, input bit ch, input longint l, input longint r);
    @(negedge clk);
    in_valid = 1'b1; in_pair = pr; in_chan = ch;
    in_left = W'(l); in_right = W'(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // drive one sample and return with the outputs of that sample on the ports
  task automatic put_get(input bit pr, input bit ch, input longint l, input longint r,
                         output longint yl, output longint yr);
    put(pr, ch, l, r);
    idle(2);
    yl = longint'(out_left);
    yr = longint'(out_right);
  endtask

  initial begin
    longint yl, yr, ya, yb, exp8, hold_r;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", longint'(out_valid), 0);
    chk(out_left == '0 && out_right == '0, "R11", longint'(out_left), 0);
    rst = 1'b0;
    idle(2);
    chk(out_valid == 1'b0 && out_left == '0, "R11", longint'(out_left), 0);

    // R2: single-channel framing echo
    put_get(1'b0, 1'b1, 0, 12345, yl, yr);
    chk(out_pair == 1'b0 && out_chan == 1'b1, "R2", longint'({out_pair, out_chan}), 1);

    // R4: DC on both channels, paired
    for (int i = 0; i < 300; i++) put(1'b1, 1'b0, 100000, -250000);
    idle(2);
    chk(absl(longint'(out_left) - 100000) <= 1, "R4", longint'(out_left), 100000);
    chk(absl(longint'(out_right) + 250000) <= 1, "R4", longint'(out_right), -250000);

    // R5: alternating input near Nyquist
    for (int i = 0; i < 200; i++) put(1'b1, 1'b0, (i % 2) ? 1000000 : -1000000, 0);
    idle(1);
    ya = longint'(out_left);
    idle(1);
    yb = longint'(out_left);
    chk((absl(ya) + absl(yb)) / 2 >= 280000 && (absl(ya) + absl(yb)) / 2 <= 320000,
        "R5", (absl(ya) + absl(yb)) / 2, 300000);

    // R8: disable clears history; first filtered sample after re-enable
    cfg_en = 1'b0;
    idle(3);
    cfg_en = 1'b1;
    idle(2);
    exp8 = (B0 * 2000000 + 64'sd2097152) >>> 22;
    put_get(1'b1, 1'b0, 2000000, 2000000, yl, yr);
    chk(yl == exp8 && yr == exp8, "R8", yl, exp8);

    // R6: enable low is bit-exact bypass
    cfg_en = 1'b0;
    idle(2);
    put_get(1'b1, 1'b0, -7654321, 8388607, yl, yr);
    chk(yl == -7654321 && yr == 8388607, "R6", yl, -7654321);
    put_get(1'b0, 1'b0, 1, 0, yl, yr);
    chk(yl == 1, "R6", yl, 1);
    cfg_en = 1'b1;

    // R7: every non-single speed code bypasses
    for (int s = 1; s < 4; s++) begin
      cfg_speed = 2'(s);
      idle(2);
      put_get(1'b1, 1'b0, 3000000 + s, -3000000 - s, yl, yr);
      chk(yl == 3000000 + s && yr == -3000000 - s, "R7", yl, 3000000 + s);
    end
    cfg_speed = 2'd0;
    idle(2);

    // R9: full-scale held inputs never wrap
    for (int i = 0; i < 300; i++) put(1'b1, 1'b0, MINV, MAXV);
    idle(2);
    chk(absl(longint'(out_left) - MINV) <= 1, "R9", longint'(out_left), MINV);
    chk(absl(longint'(out_right) - MAXV) <= 1, "R9", longint'(out_right), MAXV);
    for (int i = 0; i < 100; i++) put(1'b1, 1'b0, (i % 2) ? MAXV : MINV, (i % 2) ? MINV : MAXV);
    idle(2);

    // R10: interleaved single-channel streams keep separate history
    for (int i = 0; i < 300; i++) begin
      put(1'b0, 1'b0, 500000, 0);
      put(1'b0, 1'b1, 0, (i % 2) ? 700000 : -700000);
    end
    idle(2);
    hold_r = longint'(out_right);
    chk(absl(longint'(out_left) - 500000) <= 1, "R10", longint'(out_left), 500000);
    for (int i = 0; i < 5; i++) put(1'b0, 1'b0, -400000, 99);
    idle(2);
    chk(longint'(out_right) == hold_r, "R10", longint'(out_right), hold_r);

    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule